// File: doc/BRIEF.md
# Amplifier Protection Fault Controller

This block is the digital supervisor for a two-channel switching power stage. Each clock cycle it takes in digitised supply readings, per-channel over-current and DC-offset flags from analog comparators, a thermal-shutdown flag, a shutdown input and a 1 ms tick. From these it picks one output mode for both bridges: normal switching, held low, or high impedance. It also drives an active-low fault indication meant for an open-drain pad.

Each fault class has its own clear rule. A DC-offset fault is qualified by a persistence timer and is sticky until a power cycle, which the synchronous reset stands for. An over-current latch clears on release from shutdown. When the fault pin is wired back to the shutdown input, the same latch clears itself after a timed hold. Supply limits and thermal shutdown only hold the bridges low, and they never assert the fault pin. The supply over-voltage limit has hysteresis.

Top module: `amp_fault_ctrl`

## Requirements
- R1: After reset the mode output is 2'b10 (high impedance) and fault_n is 1. The mode stays 2'b10 until the shutdown input has been seen high, so an undriven or low shutdown input reads as shutdown.
- R2: While sd_n is low, mode is 2'b10 within four clock cycles. Shutdown by itself never drives fault_n low.
- R3: A DC-offset flag on either channel that stays high for HOLD_MS consecutive ticks declares a DC fault. If the flag drops before that, the count starts again from zero.
- R4: A DC fault drives fault_n to 0 and mode to 2'b10. Shutdown pulses and long shutdown periods do not clear it. Only reset clears it.
- R5: An over-current flag on either channel sets a latch that drives fault_n to 0 and mode to 2'b10. The latch holds after the flag drops. A rising edge of sd_n clears it.
- R6: While the over-current latch is set and sd_n is held low, the latch releases after HOLD_MS ticks. If over-current is still present, the latch stays set.
- R7: A VCC code below 75 or a regulated-rail code below 27 (both in 0.1 V units) gives mode 2'b01. Switching resumes once both codes are at or above those limits.
- R8: A VCC code above 300 gives mode 2'b01. The hold is released only when the code falls below 287.
- R9: The thermal flag gives mode 2'b01 and leaves fault_n at 1.
- R10: When high-impedance and held-low causes are active together, mode is 2'b10. The code 2'b11 is never produced.
- R11: With no cause active and shutdown released, mode is 2'b00 (switching) and fault_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, stands for a supply power cycle |
| sd_n | input | 1 | Shutdown, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| oc_flag | input | NCH | Over-current comparator flag per channel |
| dc_flag | input | NCH | DC-offset comparator flag per channel |
| hot_flag | input | 1 | Thermal shutdown flag |
| vcc_code | input | VCC_W | Speaker supply reading, 0.1 V units |
| avdd_code | input | AVDD_W | Regulated rail reading, 0.1 V units |
| mode_o | output | 2 | Bridge mode: 00 switching, 01 held low, 10 high impedance |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The supply thresholds are driven exactly at and one code past each limit. The over-voltage release is walked down through the hysteresis band, so a design that used a single threshold, or compared with the wrong inequality, would release too early or too late. The DC timer is interrupted one tick before expiry and then run to exactly HOLD_MS ticks, which exposes a timer that does not restart or that is off by one. Shutdown pulses and reset are applied to a DC fault to catch a design that clears it too easily. A feedback loop from the fault pin to shutdown exercises timed release and re-latching with the overload still present. Combined causes check that held-low never masks high impedance.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    MODE_SWITCH = 2'b00,
    MODE_LOW    = 2'b01,
    MODE_HIZ    = 2'b10
  } out_mode_e;
endpackage

// File: rtl/afc_input_sync.sv
module afc_input_sync #(
  parameter int NCH     = 2,
  parameter int VW      = 10,
  parameter int AW      = 6,
  parameter int STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sd_n,
  input  logic          tick_ms,
  input  logic [NCH-1:0] oc_flag,
  input  logic [NCH-1:0] dc_flag,
  input  logic          hot_flag,
  input  logic [VW-1:0] vcc_code,
  input  logic [AW-1:0] avdd_code,
  output logic          sd_on,
  output logic          tick_s,
  output logic          oc_any,
  output logic          dc_any,
  output logic          hot_s,
  output logic [VW-1:0] vcc_s,
  output logic [AW-1:0] avdd_s
);
  // shutdown synchronizer resets to the shutdown state
  logic [STAGES-1:0] sd_chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sd_chain <= '0;
        else     sd_chain <= sd_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sd_chain <= '0;
        else     sd_chain <= {sd_chain[STAGES-2:0], sd_n};
      end
    end
  endgenerate

  assign sd_on = sd_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_s <= 1'b0;
      oc_any <= 1'b0;
      dc_any <= 1'b0;
      hot_s  <= 1'b0;
      vcc_s  <= '0;
      avdd_s <= '0;
    end else begin
      tick_s <= tick_ms;
      oc_any <= |oc_flag;
      dc_any <= |dc_flag;
      hot_s  <= hot_flag;
      vcc_s  <= vcc_code;
      avdd_s <= avdd_code;
    end
  end
endmodule

// File: rtl/afc_supply_mon.sv
module afc_supply_mon #(
  parameter int VW       = 10,
  parameter int AW       = 6,
  parameter int OV_SET   = 300,
  parameter int OV_CLR   = 287,
  parameter int VCC_MIN  = 75,
  parameter int AVDD_MIN = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vcc_s,
  input  logic [AW-1:0] avdd_s,
  output logic          uv,
  output logic          ov
);
  localparam logic [VW-1:0] SET_C  = VW'(OV_SET);
  localparam logic [VW-1:0] CLR_C  = VW'(OV_CLR);
  localparam logic [VW-1:0] VMIN_C = VW'(VCC_MIN);
  localparam logic [AW-1:0] AMIN_C = AW'(AVDD_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      uv <= 1'b0;
      ov <= 1'b0;
    end else begin
      uv <= (vcc_s < VMIN_C) || (avdd_s < AMIN_C);
      if (vcc_s > SET_C)      ov <= 1'b1;
      else if (vcc_s < CLR_C) ov <= 1'b0;
    end
  end
endmodule

// File: rtl/afc_persist_timer.sv
module afc_persist_timer #(
  parameter int HOLD = 420
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)               cnt <= '0;
    else if (tick && cnt < LIMIT)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LIMIT);
endmodule

// File: rtl/amp_fault_ctrl.sv
module amp_fault_ctrl
  import afc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int VCC_W       = 10,
  parameter int AVDD_W      = 6,
  parameter int HOLD_MS     = 420,
  parameter int SYNC_STAGES = 2,
  parameter int OV_SET      = 300,
  parameter int OV_CLR      = 287,
  parameter int VCC_MIN     = 75,
  parameter int AVDD_MIN    = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd_n,
  input  logic              tick_ms,
  input  logic [NCH-1:0]    oc_flag,
  input  logic [NCH-1:0]    dc_flag,
  input  logic              hot_flag,
  input  logic [VCC_W-1:0]  vcc_code,
  input  logic [AVDD_W-1:0] avdd_code,
  output logic [1:0]        mode_o,
  output logic              fault_n
);
  logic              sd_on, tick_s, oc_any, dc_any, hot_s;
  logic [VCC_W-1:0]  vcc_s;
  logic [AVDD_W-1:0] avdd_s;
  logic              uv_flag, ov_flag;
  logic              sc_latch, dc_latch, sd_on_d;
  logic              dc_done, rec_done;
  logic              sd_rise;

  afc_input_sync #(
    .NCH(NCH), .VW(VCC_W), .AW(AVDD_W), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .sd_n(sd_n), .tick_ms(tick_ms),
    .oc_flag(oc_flag), .dc_flag(dc_flag), .hot_flag(hot_flag),
    .vcc_code(vcc_code), .avdd_code(avdd_code),
    .sd_on(sd_on), .tick_s(tick_s), .oc_any(oc_any), .dc_any(dc_any),
    .hot_s(hot_s), .vcc_s(vcc_s), .avdd_s(avdd_s)
  );

  afc_supply_mon #(
    .VW(VCC_W), .AW(AVDD_W), .OV_SET(OV_SET), .OV_CLR(OV_CLR),
    .VCC_MIN(VCC_MIN), .AVDD_MIN(AVDD_MIN)
  ) u_supply (
    .clk(clk), .rst(rst), .vcc_s(vcc_s), .avdd_s(avdd_s),
    .uv(uv_flag), .ov(ov_flag)
  );

  // DC offset must persist before it becomes a fault
  afc_persist_timer #(.HOLD(HOLD_MS)) u_dc_timer (
    .clk(clk), .rst(rst), .run(dc_any && !dc_latch), .tick(tick_s),
    .done(dc_done)
  );

  // timed release of the short latch while shutdown is held low
  afc_persist_timer #(.HOLD(HOLD_MS)) u_rec_timer (
    .clk(clk), .rst(rst), .run(sc_latch && !sd_on), .tick(tick_s),
    .done(rec_done)
  );

  assign sd_rise = sd_on && !sd_on_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_on_d  <= 1'b0;
      sc_latch <= 1'b0;
      dc_latch <= 1'b0;
    end else begin
      sd_on_d <= sd_on;
      if (dc_done) dc_latch <= 1'b1;
      // a present overload wins over any clear request
      if (oc_any)                    sc_latch <= 1'b1;
      else if (rec_done || sd_rise)  sc_latch <= 1'b0;
    end
  end

  out_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_HIZ;
      fault_n <= 1'b1;
    end else begin
      if (!sd_on || sc_latch || dc_latch)    mode_q <= MODE_HIZ;
      else if (uv_flag || ov_flag || hot_s)  mode_q <= MODE_LOW;
      else                                   mode_q <= MODE_SWITCH;
      fault_n <= !(sc_latch || dc_latch);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int VW     = 10,
  parameter int OV_CLR = 287
) (
  input logic          clk,
  input logic          rst,
  input logic          sd_on,
  input logic          sc_latch,
  input logic          dc_latch,
  input logic          ov_flag,
  input logic [VW-1:0] vcc_s,
  input logic [1:0]    mode_o,
  input logic          fault_n
);
  a_r2_shutdown_hiz: assert property (@(posedge clk) disable iff (rst)
    !sd_on |=> mode_o == 2'b10);

  a_r4_dc_sticky: assert property (@(posedge clk) disable iff (rst)
    dc_latch |=> dc_latch);

  a_r5_latch_pulls_fault: assert property (@(posedge clk) disable iff (rst)
    sc_latch |=> !fault_n);

  a_r5_fault_means_hiz: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> mode_o == 2'b10);

  a_r8_ov_hysteresis: assert property (@(posedge clk) disable iff (rst)
    (ov_flag && vcc_s >= VW'(OV_CLR)) |=> ov_flag);

  a_r9_low_keeps_fault_high: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'b01 |-> fault_n);

  a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b11);
endmodule

bind amp_fault_ctrl afc_checker #(.VW(VCC_W), .OV_CLR(OV_CLR)) u_afc_chk (
  .clk(clk), .rst(rst), .sd_on(sd_on), .sc_latch(sc_latch),
  .dc_latch(dc_latch), .ov_flag(ov_flag), .vcc_s(vcc_s),
  .mode_o(mode_o), .fault_n(fault_n)
);

// File: tb/tb_amp_fault_ctrl.sv
module tb_amp_fault_ctrl;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sd_drv = 1'b0;
  logic       loop_en = 1'b0;
  logic       sd_n;
  logic       tick_ms = 1'b0;
  logic [1:0] oc_flag = '0;
  logic [1:0] dc_flag = '0;
  logic       hot_flag = 1'b0;
  logic [9:0] vcc_code = 10'd240;
  logic [5:0] avdd_code = 6'd33;
  logic [1:0] mode_o;
  logic       fault_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // fault pin optionally wired back to shutdown
  assign sd_n = loop_en ? fault_n : sd_drv;

  amp_fault_ctrl #(.HOLD_MS(HOLD)) dut (
    .clk(clk), .rst(rst), .sd_n(sd_n), .tick_ms(tick_ms),
    .oc_flag(oc_flag), .dc_flag(dc_flag), .hot_flag(hot_flag),
    .vcc_code(vcc_code), .avdd_code(avdd_code),
    .mode_o(mode_o), .fault_n(fault_n)
  );

  // {vcc, avdd, hot, expected mode}; rows run in order for hysteresis
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {10'd240, 6'd33, 1'b0, 2'b00},
    {10'd74,  6'd33, 1'b0, 2'b01},
    {10'd75,  6'd33, 1'b0, 2'b00},
    {10'd240, 6'd26, 1'b0, 2'b01},
    {10'd240, 6'd27, 1'b0, 2'b00},
    {10'd300, 6'd33, 1'b0, 2'b00},
    {10'd301, 6'd33, 1'b0, 2'b01},
    {10'd290, 6'd33, 1'b0, 2'b01},
    {10'd287, 6'd33, 1'b0, 2'b01},
    {10'd286, 6'd33, 1'b0, 2'b00},
    {10'd240, 6'd33, 1'b1, 2'b01},
    {10'd240, 6'd33, 1'b0, 2'b00}
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; @(negedge clk);
      tick_ms = 1'b0; @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    // R1: reset state, shutdown still low
    check("R1 mode after reset", mode_o, 2);
    check("R1 fault_n after reset", fault_n, 1);
    sd_drv = 1'b1;
    wait_cyc(6);
    check("R11 switching once released", mode_o, 0);

    // R7 R8 R9 R11: supply and thermal table
    for (int v = 0; v < NV; v++) begin
      vcc_code  = VEC[v][18:9];
      avdd_code = VEC[v][8:3];
      hot_flag  = VEC[v][2];
      wait_cyc(6);
      check($sformatf("R7/R8/R9 row %0d mode", v), mode_o, int'(VEC[v][1:0]));
      check($sformatf("R9 row %0d fault_n", v), fault_n, 1);
    end

    // R2: shutdown gives high impedance, no fault
    sd_drv = 1'b0;
    wait_cyc(4);
    check("R2 mode in shutdown", mode_o, 2);
    check("R2 fault_n in shutdown", fault_n, 1);
    // R10: shutdown plus undervoltage
    vcc_code = 10'd50;
    wait_cyc(6);
    check("R10 hiz over low", mode_o, 2);
    vcc_code = 10'd240;
    sd_drv = 1'b1;
    wait_cyc(6);
    check("R2 released", mode_o, 0);

    // R5: over-current latch on channel 0
    oc_flag = 2'b01; wait_cyc(2); oc_flag = 2'b00;
    wait_cyc(6);
    check("R5 fault_n latched", fault_n, 0);
    check("R5 mode latched", mode_o, 2);
    wait_cyc(20);
    check("R5 latch holds", fault_n, 0);
    sd_drv = 1'b0; wait_cyc(4); sd_drv = 1'b1;
    wait_cyc(8);
    check("R5 cleared by shutdown pulse", fault_n, 1);
    check("R5 mode after clear", mode_o, 0);
    // channel 1
    oc_flag = 2'b10; wait_cyc(2); oc_flag = 2'b00;
    wait_cyc(6);
    check("R5 channel 1 latch", fault_n, 0);
    sd_drv = 1'b0; wait_cyc(4); sd_drv = 1'b1;
    wait_cyc(8);
    check("R5 channel 1 cleared", fault_n, 1);

    // R6: auto recovery loop
    loop_en = 1'b1;
    oc_flag = 2'b01; wait_cyc(2); oc_flag = 2'b00;
    wait_cyc(10);
    check("R6 latched in loop", fault_n, 0);
    ticks(HOLD - 1);
    wait_cyc(6);
    check("R6 not released early", fault_n, 0);
    ticks(1);
    wait_cyc(10);
    check("R6 released after hold", fault_n, 1);
    check("R6 switching after release", mode_o, 0);
    oc_flag = 2'b01;
    wait_cyc(10);
    ticks(HOLD + 2);
    wait_cyc(10);
    check("R6 relatch with overload present", fault_n, 0);
    oc_flag = 2'b00;
    wait_cyc(10);
    check("R6 release once overload gone", fault_n, 1);
    check("R6 mode once overload gone", mode_o, 0);
    loop_en = 1'b0;
    sd_drv = 1'b1;
    wait_cyc(6);

    // R3: DC persistence with restart
    dc_flag = 2'b10;
    wait_cyc(2);
    ticks(HOLD - 1);
    dc_flag = 2'b00;
    wait_cyc(4);
    dc_flag = 2'b10;
    wait_cyc(2);
    ticks(HOLD - 1);
    wait_cyc(6);
    check("R3 no fault before hold", fault_n, 1);
    check("R3 still switching", mode_o, 0);
    ticks(1);
    wait_cyc(6);
    check("R3 fault at hold", fault_n, 0);
    check("R4 mode on dc fault", mode_o, 2);
    dc_flag = 2'b00;

    // R4: shutdown does not clear DC fault
    sd_drv = 1'b0; wait_cyc(4); sd_drv = 1'b1;
    wait_cyc(8);
    check("R4 survives shutdown pulse", fault_n, 0);
    sd_drv = 1'b0;
    wait_cyc(4);
    ticks(HOLD + 4);
    sd_drv = 1'b1;
    wait_cyc(8);
    check("R4 survives long shutdown", fault_n, 0);
    vcc_code = 10'd50;
    wait_cyc(6);
    check("R10 dc fault over undervoltage", mode_o, 2);
    vcc_code = 10'd240;
    rst = 1'b1; wait_cyc(3); rst = 1'b0;
    wait_cyc(2);
    check("R4 reset clears fault", fault_n, 1);
    check("R1 mode right after reset", mode_o, 2);
    wait_cyc(6);
    check("R11 switching after power cycle", mode_o, 0);

    finish_run();
  end
endmodule